// File: doc/BRIEF.md
# Multi-queue transmit priority scheduler

The scheduler picks the next transmit descriptor out of a set of circular descriptor queues, sixteen by default, and routes it to one of eight output channels. Each queue has a write pointer, a read pointer and a status word, all loaded through a single configuration write port. The status word selects the queue's output channel and carries an active flag and a block-ack enable flag. Several queues may feed the same channel. Each queue feeds exactly one channel.

In every cycle the block works out which queues are eligible. A queue is eligible when it is active, holds at least one descriptor (write pointer differs from read pointer, modulo 256), and its channel is not signalling full. Among the channels that have an eligible queue, the highest channel number wins: 7 carries commands, 3 carries voice and management, 2 video, 1 best effort and 0 background. Queues on the winning channel take turns in round-robin order. The grant is registered. It carries the queue number, the channel, the read pointer of the descriptor and a chain flag, and that queue's read pointer then advances by one.

The chain flag marks a descriptor that may join a block-ack chain. It is the queue's block-ack enable ANDed with a per-queue chain mask. After reset the mask covers every queue except the command queue.

Top module: `txq_sched`

## Requirements
- R1: After reset, grant_valid is 0, every queue is inactive, every pointer is 0, and no grant appears until a queue is configured.
- R2: A queue is granted only when its active bit is 1, its write pointer differs from its read pointer, and ch_full for its channel was 0 in the cycle before the grant appears.
- R3: When several channels have eligible queues, the grant goes to the highest channel number.
- R4: Queues eligible on the same channel are served round-robin in increasing queue number, wrapping around. After reset the search for each channel starts at queue 0.
- R5: A grant reports the queue, its channel and its read pointer. That read pointer then increments modulo 256, so 255 is followed by 0, and the queue stops when the read pointer reaches the write pointer.
- R6: At most one grant per cycle. Whenever any queue is eligible in a cycle, grant_valid is 1 in the next cycle.
- R7: The status word decodes as channel in bits 2:0, active in bit 3 and block-ack enable in bit 19. All other bits have no effect.
- R8: grant_chain equals the queue's block-ack enable ANDed with its chain-mask bit. The mask resets to all ones except bit CMD_Q (default 4), and a mask write loads cfg_wdata[NUM_Q-1:0].
- R9: cfg_kind selects the target: 0 write pointer, 1 read pointer, 2 status, 3 chain mask. A read-pointer write in the same cycle as a grant to that queue takes precedence over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 wptr, 1 rptr, 2 status, 3 chain mask |
| cfg_queue | input | 4 | Queue addressed by the write |
| cfg_wdata | input | 32 | Write data |
| ch_full | input | 8 | Per-channel full indication |
| grant_valid | output | 1 | A grant is presented this cycle |
| grant_queue | output | 4 | Granted queue |
| grant_chan | output | 3 | Channel of the granted queue |
| grant_rptr | output | 8 | Read pointer of the granted descriptor |
| grant_chain | output | 1 | Descriptor may join a block-ack chain |

## Verification
Corrupted pointer state shows up at the ports within one cycle of the next grant on that queue. It appears as a skipped or repeated grant_rptr value, or as a grant that does not stop once the queue is empty. A damaged round-robin pointer or channel decode shows up as grants in the wrong order or on the wrong grant_chan as soon as two queues compete. A lost eligibility term shows up either as a grant into a full channel or as an idle cycle while work is pending, one cycle after the cause.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

  typedef enum logic [1:0] {
    CFG_WPTR  = 2'd0,
    CFG_RPTR  = 2'd1,
    CFG_STAT  = 2'd2,
    CFG_CHAIN = 2'd3
  } cfg_kind_e;

  // status word field positions (software encodes these)
  localparam int STAT_CH_LSB   = 0;
  localparam int STAT_ACT_BIT  = 3;
  localparam int STAT_SACK_BIT = 19;

endpackage

// File: rtl/txq_queue_regs.sv
module txq_queue_regs
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q = 16,
  parameter int PTR_W = 8,
  parameter int CH_W  = 3,
  parameter int CMD_Q = 4,
  parameter int Q_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_kind,
  input  logic [Q_W-1:0]               cfg_queue,
  input  logic [31:0]                  cfg_wdata,
  input  logic                         adv_en,
  input  logic [Q_W-1:0]               adv_q,
  output logic [NUM_Q-1:0][PTR_W-1:0]  wptr,
  output logic [NUM_Q-1:0][PTR_W-1:0]  rptr,
  output logic [NUM_Q-1:0][CH_W-1:0]   chan,
  output logic [NUM_Q-1:0]             active,
  output logic [NUM_Q-1:0]             sack,
  output logic [NUM_Q-1:0]             chain_mask
);

  localparam logic [NUM_Q-1:0] MASK_RST = ~(NUM_Q'(1) << CMD_Q);

  logic [NUM_Q-1:0] mask_d;
  logic             mask_en;

  always_comb begin
    mask_en = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_CHAIN);
    mask_d  = cfg_wdata[NUM_Q-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain_mask <= MASK_RST;
    else if (mask_en) chain_mask <= mask_d;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic             hit;
    logic             wp_en, rp_en, st_en;
    logic [PTR_W-1:0] wp_d, rp_d;
    logic [CH_W-1:0]  ch_d;
    logic             act_d, sack_d;

    always_comb begin
      hit    = cfg_we && (cfg_queue == Q_W'(q));
      wp_en  = hit && (cfg_kind_e'(cfg_kind) == CFG_WPTR);
      st_en  = hit && (cfg_kind_e'(cfg_kind) == CFG_STAT);
      wp_d   = cfg_wdata[PTR_W-1:0];
      ch_d   = cfg_wdata[STAT_CH_LSB +: CH_W];
      act_d  = cfg_wdata[STAT_ACT_BIT];
      sack_d = cfg_wdata[STAT_SACK_BIT];
      // a software write wins over the grant advance
      if (hit && (cfg_kind_e'(cfg_kind) == CFG_RPTR)) begin
        rp_en = 1'b1;
        rp_d  = cfg_wdata[PTR_W-1:0];
      end else if (adv_en && (adv_q == Q_W'(q))) begin
        rp_en = 1'b1;
        rp_d  = rptr[q] + PTR_W'(1);
      end else begin
        rp_en = 1'b0;
        rp_d  = rptr[q];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wptr[q]   <= '0;
        rptr[q]   <= '0;
        chan[q]   <= '0;
        active[q] <= 1'b0;
        sack[q]   <= 1'b0;
      end else begin
        if (wp_en) wptr[q] <= wp_d;
        if (rp_en) rptr[q] <= rp_d;
        if (st_en) begin
          chan[q]   <= ch_d;
          active[q] <= act_d;
          sack[q]   <= sack_d;
        end
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[31:20], cfg_wdata[18:PTR_W]};

endmodule

// File: rtl/txq_elig.sv
module txq_elig #(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_Q-1:0][PTR_W-1:0] wptr,
  input  logic [NUM_Q-1:0][PTR_W-1:0] rptr,
  input  logic [NUM_Q-1:0][CH_W-1:0]  chan,
  input  logic [NUM_Q-1:0]            active,
  input  logic [NUM_CH-1:0]           ch_full,
  output logic [NUM_Q-1:0]            elig,
  output logic                        any_elig
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_e
    assign elig[q] = active[q] && (wptr[q] != rptr[q]) && !ch_full[chan[q]];
  end

  assign any_elig = |elig;

endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter #(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int Q_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_Q-1:0]           elig,
  input  logic [NUM_Q-1:0][CH_W-1:0] chan,
  output logic                       pick_valid,
  output logic [Q_W-1:0]             pick_q,
  output logic [CH_W-1:0]            pick_ch
);

  logic [NUM_CH-1:0]          ch_req;
  logic [NUM_Q-1:0]           cand;
  logic [NUM_CH-1:0][Q_W-1:0] last_q;
  logic [Q_W-1:0]             start;

  // channel level: higher channel number has higher priority
  always_comb begin
    ch_req  = '0;
    pick_ch = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (elig[q]) ch_req[chan[q]] = 1'b1;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_req[c]) pick_ch = CH_W'(c);
    end
  end

  // queue level: rotate from the queue after the last one served
  always_comb begin
    pick_valid = 1'b0;
    pick_q     = '0;
    start      = last_q[pick_ch];
    for (int q = 0; q < NUM_Q; q++) begin
      cand[q] = elig[q] && (chan[q] == pick_ch);
    end
    for (int off = 1; off <= NUM_Q; off++) begin
      int k;
      k = (int'(start) + off) % NUM_Q;
      if (!pick_valid && cand[k]) begin
        pick_valid = 1'b1;
        pick_q     = Q_W'(k);
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rr
    logic rr_en;
    assign rr_en = pick_valid && (pick_ch == CH_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last_q[c] <= Q_W'(NUM_Q - 1);
      else if (rr_en) last_q[c] <= pick_q;
    end
  end

endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  parameter int CMD_Q  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_kind,
  input  logic [$clog2(NUM_Q)-1:0]   cfg_queue,
  input  logic [31:0]                cfg_wdata,
  input  logic [NUM_CH-1:0]          ch_full,
  output logic                       grant_valid,
  output logic [$clog2(NUM_Q)-1:0]   grant_queue,
  output logic [$clog2(NUM_CH)-1:0]  grant_chan,
  output logic [PTR_W-1:0]           grant_rptr,
  output logic                       grant_chain
);

  localparam int Q_W  = $clog2(NUM_Q);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_Q-1:0][PTR_W-1:0] wptr, rptr;
  logic [NUM_Q-1:0][CH_W-1:0]  chan;
  logic [NUM_Q-1:0]            active, sack, chain_mask, elig;
  logic                        any_elig;
  logic                        pick_valid;
  logic [Q_W-1:0]              pick_q;
  logic [CH_W-1:0]             pick_ch;
  logic [PTR_W-1:0]            rptr_d;
  logic                        chain_d;

  txq_queue_regs #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .CH_W(CH_W), .CMD_Q(CMD_Q), .Q_W(Q_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_queue(cfg_queue), .cfg_wdata(cfg_wdata),
    .adv_en(pick_valid), .adv_q(pick_q),
    .wptr(wptr), .rptr(rptr), .chan(chan), .active(active),
    .sack(sack), .chain_mask(chain_mask)
  );

  txq_elig #(
    .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .PTR_W(PTR_W), .CH_W(CH_W)
  ) u_elig (
    .wptr(wptr), .rptr(rptr), .chan(chan), .active(active),
    .ch_full(ch_full), .elig(elig), .any_elig(any_elig)
  );

  txq_arbiter #(
    .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CH_W(CH_W), .Q_W(Q_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .chan(chan),
    .pick_valid(pick_valid), .pick_q(pick_q), .pick_ch(pick_ch)
  );

  always_comb begin
    rptr_d  = rptr[pick_q];
    chain_d = sack[pick_q] && chain_mask[pick_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_queue <= '0;
      grant_chan  <= '0;
      grant_rptr  <= '0;
      grant_chain <= 1'b0;
    end else begin
      grant_valid <= pick_valid;
      if (pick_valid) begin
        grant_queue <= pick_q;
        grant_chan  <= pick_ch;
        grant_rptr  <= rptr_d;
        grant_chain <= chain_d;
      end
    end
  end

endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  parameter int Q_W    = 4,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [NUM_CH-1:0] ch_full,
  input logic              any_elig,
  input logic              grant_valid,
  input logic [Q_W-1:0]    grant_queue,
  input logic [CH_W-1:0]   grant_chan,
  input logic [PTR_W-1:0]  grant_rptr
);

  logic [NUM_CH-1:0] full_q;
  logic              elig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      elig_q <= 1'b0;
    end else begin
      full_q <= ch_full;
      elig_q <= any_elig;
    end
  end

  // R2
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !full_q[grant_chan]);

  // R2
  grant_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> elig_q);

  // R6
  work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |=> grant_valid);

  // R5
  rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && $past(grant_valid) && grant_queue == $past(grant_queue)
     && !$past(cfg_we) && !$past(cfg_we, 2))
    |-> grant_rptr == PTR_W'($past(grant_rptr) + 1));

endmodule

bind txq_sched txq_sched_chk #(
  .NUM_CH(NUM_CH), .PTR_W(PTR_W), .Q_W(Q_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .ch_full(ch_full),
  .any_elig(any_elig), .grant_valid(grant_valid), .grant_queue(grant_queue),
  .grant_chan(grant_chan), .grant_rptr(grant_rptr)
);

// File: tb/txq_sched_tb.sv
`timescale 1ns/1ps
module txq_sched_tb;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_kind;
  logic [3:0]  cfg_queue;
  logic [31:0] cfg_wdata;
  logic [7:0]  ch_full;
  logic        grant_valid;
  logic [3:0]  grant_queue;
  logic [2:0]  grant_chan;
  logic [7:0]  grant_rptr;
  logic        grant_chain;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected grant packed as {chain, queue, chan, rptr}
  logic [15:0] exp_q[$];
  string       tag_q[$];

  txq_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_queue(cfg_queue), .cfg_wdata(cfg_wdata), .ch_full(ch_full),
    .grant_valid(grant_valid), .grant_queue(grant_queue),
    .grant_chan(grant_chan), .grant_rptr(grant_rptr), .grant_chain(grant_chain)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int q, input int ch, input int rp, input int chain, input string tag);
    exp_q.push_back({chain[0], q[3:0], ch[2:0], rp[7:0]});
    tag_q.push_back(tag);
  endtask

  task automatic cfg(input int kind, input int q, input logic [31:0] d);
    cfg_we = 1; cfg_kind = kind[1:0]; cfg_queue = q[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " missing grants"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  // monitor: compare every grant against the scoreboard
  always @(negedge clk) begin
    if (rst_n && grant_valid) begin
      logic [15:0] act;
      act = {grant_chain, grant_queue, grant_chan, grant_rptr};
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected grant", int'(act), -1);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act == e, t, int'(act), int'(e));
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_kind = 0; cfg_queue = 0; cfg_wdata = 0; ch_full = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1: nothing configured, channels free -> no grant
    chk(grant_valid == 0, "R1 idle after reset", grant_valid, 0);

    // R5 basic: q1 on ch1 with three descriptors
    ch_full = 8'hFF;
    cfg(2, 1, 32'h9); cfg(0, 1, 32'd3);
    push(1, 1, 0, 0, "R5 q1 d0"); push(1, 1, 1, 0, "R5 q1 d1"); push(1, 1, 2, 0, "R5 q1 d2");
    ch_full = 8'h00;
    drain("R5");

    // R3: channels 0, 3, 7 compete
    ch_full = 8'hFF;
    cfg(2, 2, 32'h8);  cfg(0, 2, 32'd2);
    cfg(2, 5, 32'hB);  cfg(0, 5, 32'd2);
    cfg(2, 6, 32'hF);  cfg(0, 6, 32'd1);
    push(6, 7, 0, 0, "R3 ch7 first");
    push(5, 3, 0, 0, "R3 ch3 a"); push(5, 3, 1, 0, "R3 ch3 b");
    push(2, 0, 0, 0, "R3 ch0 a"); push(2, 0, 1, 0, "R3 ch0 b");
    ch_full = 8'h00;
    drain("R3");

    // R4: three queues on ch2 rotate
    ch_full = 8'hFF;
    cfg(2, 8, 32'hA);  cfg(0, 8, 32'd2);
    cfg(2, 9, 32'hA);  cfg(0, 9, 32'd2);
    cfg(2, 10, 32'hA); cfg(0, 10, 32'd2);
    for (int r = 0; r < 2; r++)
      for (int q = 8; q <= 10; q++) push(q, 2, r, 0, "R4 round-robin");
    ch_full = 8'h00;
    drain("R4");

    // R2: full channel blocks, release lets it through
    ch_full = 8'hFF;
    cfg(2, 11, 32'h9); cfg(0, 11, 32'd1);
    ch_full = 8'h02;
    repeat (6) @(negedge clk);
    chk(grant_valid == 0, "R2 full channel blocks", grant_valid, 0);
    push(11, 1, 0, 0, "R2 after release");
    ch_full = 8'h00;
    drain("R2 full");

    // R2 inactive queue ignored; R7 stray status bits have no effect
    cfg(2, 12, 32'h1); cfg(0, 12, 32'd1);
    repeat (6) @(negedge clk);
    chk(grant_valid == 0, "R2 inactive queue", grant_valid, 0);
    push(12, 1, 0, 0, "R7 stray bits ignored");
    cfg(2, 12, 32'h5A70_0A09);
    drain("R7");

    // R5 wrap 254, 255, 0
    ch_full = 8'hFF;
    cfg(2, 13, 32'h8); cfg(1, 13, 32'd254); cfg(0, 13, 32'd0);
    push(13, 0, 254, 0, "R5 wrap 254"); push(13, 0, 255, 0, "R5 wrap 255");
    ch_full = 8'h00;
    drain("R5 wrap");
    push(13, 0, 0, 0, "R5 after wrap 0");
    cfg(0, 13, 32'd1);
    drain("R5 wrap2");

    // R8 chain flag and mask default excluding CMD_Q=4
    ch_full = 8'hFF;
    cfg(2, 3, 32'h0008_0009); cfg(0, 3, 32'd1);
    cfg(2, 4, 32'h0008_000F); cfg(0, 4, 32'd1);
    push(4, 7, 0, 0, "R8 cmd queue not chained");
    push(3, 1, 0, 1, "R8 chained queue");
    ch_full = 8'h00;
    drain("R8");
    push(4, 7, 1, 1, "R8 mask written");
    cfg(3, 0, 32'h0000_FFFF); cfg(0, 4, 32'd2);
    drain("R8 mask");

    // R9: rptr write in the grant cycle wins over the increment
    ch_full = 8'hFF;
    cfg(2, 14, 32'h9); cfg(0, 14, 32'd5);
    push(14, 1, 0, 0, "R9 first grant"); push(14, 1, 3, 0, "R9 write wins");
    push(14, 1, 4, 0, "R9 continue");
    ch_full = 8'h00;
    cfg(1, 14, 32'd3);
    drain("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule